// File: doc/BRIEF.md
# Strobed Watchdog Timer with Timeout Write Lock

This block is a watchdog timer that counts in steps of a 32 Hz tick, one step being 31.25 ms. Software controls it through one 8-bit register on a simple synchronous bus. A write enable and a write data byte update the register. The read data is a combinational view of the register.

The register holds three fields:
- a self-clearing restart (strobe) bit;
- a write-protect bit for the timeout field;
- a 6-bit timeout multiplier.

Software arms or restarts the countdown by writing the strobe bit. If the countdown runs out before the next strobe, the block gives a one-clock expiry pulse and sets a sticky watchdog flag. The flag stays set until the flag-clear input is driven, which happens when the flags register is read. The tick comes from a prescaler outside this block.

The protect bit lets firmware restart the timer without risk of changing its timeout setting. The protect bit in force before a write decides whether that write may change the timeout field. A write that clears the protect bit therefore unlocks only the writes that follow it.

Top module: `strobe_wdog`

## Requirements
- R1: After reset the read data is 0x00: timeout 0, protect bit 0. The expiry pulse and the watchdog flag are both low.
- R2: The read data shows the protect bit in bit 6 and the timeout multiplier in bits 5..0. Bit 7 (the strobe position) always reads 0.
- R3: A write with bit 7 set loads the countdown with the timeout value that the field holds after that write. A write with bit 7 clear does not load or restart the countdown.
- R4: If the protect bit is 1 before a write, that write leaves the timeout field unchanged. The protect bit itself takes bit 6 of every write.
- R5: A write that clears the protect bit does not change the timeout field in that same write. The next write with the protect bit still 0 before it stores bits 5..0.
- R6: The countdown moves only on clock cycles with the tick input high. After a load with value N (N>0), the Nth tick gives a one-clock expiry pulse and sets the watchdog flag, both visible after that tick's clock edge.
- R7: A strobe that loads timeout value 0 leaves the watchdog disabled: no number of ticks produces an expiry.
- R8: Changing the timeout field while a countdown runs does not change that countdown. The new value is used only at the next strobe.
- R9: The watchdog flag stays set until the flag-clear input is high. If an expiry and flag-clear fall on the same cycle, the flag stays set.
- R10: A strobe in the same cycle as a tick reloads the countdown, and that tick is not counted.
- R11: After an expiry the countdown stays idle. No further expiry pulse occurs until the next strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write enable, one write per cycle high |
| wrData | input | 8 | Write data: bit 7 strobe, bit 6 protect, bits 5..0 timeout |
| tickEn | input | 1 | 32 Hz step enable, high for one clock per step |
| flagClr | input | 1 | Clears the sticky watchdog flag (driven on a flags read) |
| rdData | output | 8 | Register read view, bit 7 always 0 |
| expiredPulse | output | 1 | One-clock pulse when the countdown expires |
| wdogFlag | output | 1 | Sticky watchdog timeout flag |

## Verification
The hardest situations to reach from the ports are those where two events land in the same clock cycle:
- a strobe meets a tick;
- an expiry meets a flag clear;
- a write clears the protect bit while it also carries new timeout bits.

Sequences of this kind often end in a state that the register read-back cannot tell apart from the expected one. The stimulus therefore builds each collision on purpose. It counts the ticks up to the cycle just before expiry, then drives the competing input in exactly that cycle. A behavioural reference model is compared against the read data, the pulse and the flag on every clock, so a countdown that is off by one step shows up.

// File: rtl/strobe_wdog_pkg.sv
package strobe_wdog_pkg;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic reload;     // load countdown from timeout value
    logic tmoWrite;   // timeout field accepts write data
    logic lockWrite;  // protect bit takes write data
    logic countStep;  // decrement countdown
    logic expire;     // this step ends the countdown
  } wdogCtl_t;

endpackage

// File: rtl/strobe_wdog_ctrl.sv
module strobe_wdog_ctrl
  import strobe_wdog_pkg::*;
(
  input  logic     wrEn,
  input  logic     wrStrobe,
  input  logic     tickEn,
  input  logic     lockQ,
  input  logic     cntActive,
  input  logic     cntLast,
  output wdogCtl_t ctl
);

  always_comb begin
    ctl           = '0;
    ctl.reload    = wrEn & wrStrobe;
    // protect bit held before this write governs the field
    ctl.tmoWrite  = wrEn & ~lockQ;
    ctl.lockWrite = wrEn;
    // a reload in the same cycle takes priority over a tick
    ctl.countStep = tickEn & cntActive & ~ctl.reload;
    ctl.expire    = ctl.countStep & cntLast;
  end

endmodule

// File: rtl/strobe_wdog_datapath.sv
module strobe_wdog_datapath
  import strobe_wdog_pkg::*;
#(
  parameter int TMO_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdogCtl_t         ctl,
  input  logic [TMO_W-1:0] wrTmo,
  input  logic             wrLock,
  input  logic             flagClr,
  output logic [TMO_W-1:0] tmoQ,
  output logic             lockQ,
  output logic             cntActive,
  output logic             cntLast,
  output logic             expiredPulse,
  output logic             wdogFlag
);

  localparam logic [TMO_W-1:0] ONE = TMO_W'(1);

  logic [TMO_W-1:0] cntQ;
  logic [TMO_W-1:0] tmoNext;

  assign tmoNext   = ctl.tmoWrite ? wrTmo : tmoQ;
  assign cntActive = (cntQ != '0);
  assign cntLast   = (cntQ == ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmoQ  <= '0;
      lockQ <= 1'b0;
    end else begin
      tmoQ <= tmoNext;
      if (ctl.lockWrite) lockQ <= wrLock;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (ctl.reload) begin
      cntQ <= tmoNext;
    end else if (ctl.countStep) begin
      cntQ <= cntQ - ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expiredPulse <= 1'b0;
      wdogFlag     <= 1'b0;
    end else begin
      expiredPulse <= ctl.expire;
      if (ctl.expire)   wdogFlag <= 1'b1;
      else if (flagClr) wdogFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/strobe_wdog.sv
module strobe_wdog
  import strobe_wdog_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              tickEn,
  input  logic              flagClr,
  output logic [DATA_W-1:0] rdData,
  output logic              expiredPulse,
  output logic              wdogFlag
);

  localparam int STROBE_BIT = DATA_W - 1;
  localparam int LOCK_BIT   = DATA_W - 2;
  localparam int TMO_W      = DATA_W - 2;

  wdogCtl_t         ctl;
  logic [TMO_W-1:0] tmoQ;
  logic             lockQ;
  logic             cntActive;
  logic             cntLast;

  strobe_wdog_ctrl ctrl_i (
    .wrEn      (wrEn),
    .wrStrobe  (wrData[STROBE_BIT]),
    .tickEn    (tickEn),
    .lockQ     (lockQ),
    .cntActive (cntActive),
    .cntLast   (cntLast),
    .ctl       (ctl)
  );

  strobe_wdog_datapath #(.TMO_W(TMO_W)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .wrTmo        (wrData[TMO_W-1:0]),
    .wrLock       (wrData[LOCK_BIT]),
    .flagClr      (flagClr),
    .tmoQ         (tmoQ),
    .lockQ        (lockQ),
    .cntActive    (cntActive),
    .cntLast      (cntLast),
    .expiredPulse (expiredPulse),
    .wdogFlag     (wdogFlag)
  );

  // strobe position is write-only and always reads as zero
  assign rdData = {1'b0, lockQ, tmoQ};

endmodule

// File: rtl/strobe_wdog_checker.sv
module strobe_wdog_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic              tickEn,
  input logic              flagClr,
  input logic [DATA_W-1:0] rdData,
  input logic              expiredPulse,
  input logic              wdogFlag
);

  localparam int LOCK_BIT = DATA_W - 2;
  localparam int TMO_W    = DATA_W - 2;

  // R4: locked field keeps its value across a write
  p_locked_field_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && rdData[LOCK_BIT]) |=> $stable(rdData[TMO_W-1:0]));

  // R5: unlocked write stores the new timeout bits
  p_unlocked_store_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !rdData[LOCK_BIT]) |=> (rdData[TMO_W-1:0] == $past(wrData[TMO_W-1:0])));

  // R2: without a write the register view does not move
  p_reg_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(rdData));

  // R6: no expiry without a tick on the preceding cycle
  p_tick_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> !expiredPulse);

  // R6: an expiry always comes with the flag set
  p_pulse_sets_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    expiredPulse |-> wdogFlag);

  // R11: expiry pulse never lasts two cycles
  p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    expiredPulse |=> !expiredPulse);

  // R9: flag is sticky until cleared
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wdogFlag && !flagClr) |=> wdogFlag);

  // R9: a clear drops the flag unless an expiry arrives with it
  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    flagClr |=> (!wdogFlag || expiredPulse));

endmodule

bind strobe_wdog strobe_wdog_checker #(.DATA_W(DATA_W)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .wrEn         (wrEn),
  .wrData       (wrData),
  .tickEn       (tickEn),
  .flagClr      (flagClr),
  .rdData       (rdData),
  .expiredPulse (expiredPulse),
  .wdogFlag     (wdogFlag)
);

// File: tb/strobe_wdog_tb_top.sv
module strobe_wdog_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       tickEn = 1'b0;
  logic       flagClr = 1'b0;
  logic [7:0] rdData;
  logic       expiredPulse;
  logic       wdogFlag;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int pulseCount = 0;
  bit done = 1'b0;

  // behavioural reference state
  int mTmo = 0;
  int mLock = 0;
  int mCnt = 0;
  int mFlag = 0;
  int mPulse = 0;

  strobe_wdog dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (wrEn),
    .wrData       (wrData),
    .tickEn       (tickEn),
    .flagClr      (flagClr),
    .rdData       (rdData),
    .expiredPulse (expiredPulse),
    .wdogFlag     (wdogFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // reference model, advanced at each rising edge
  always @(posedge clk) begin
    int nPulse;
    if (!rstN) begin
      mTmo = 0; mLock = 0; mCnt = 0; mFlag = 0; mPulse = 0;
    end else begin
      nPulse = 0;
      if (wrEn) begin
        if (mLock == 0) mTmo = int'(wrData[5:0]);
        mLock = int'(wrData[6]);
      end
      if (wrEn && wrData[7]) mCnt = mTmo;
      else if (tickEn && mCnt > 0) begin
        mCnt = mCnt - 1;
        if (mCnt == 0) nPulse = 1;
      end
      if (nPulse == 1) mFlag = 1;
      else if (flagClr) mFlag = 0;
      mPulse = nPulse;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(rdData == 8'((mLock << 6) | mTmo), "R2 model rdData",
            int'(rdData), (mLock << 6) | mTmo);
      check(int'(expiredPulse) == mPulse, "R6 model expiredPulse", int'(expiredPulse), mPulse);
      check(int'(wdogFlag) == mFlag, "R9 model wdogFlag", int'(wdogFlag), mFlag);
      if (expiredPulse) pulseCount++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG_CYCLES && !done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG_CYCLES);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] d, input logic withTick);
    wrEn = 1'b1; wrData = d; tickEn = withTick;
    @(negedge clk);
    wrEn = 1'b0; tickEn = 1'b0;
  endtask

  task automatic ticks(input int n, input logic gap);
    for (int i = 0; i < n; i++) begin
      tickEn = 1'b1;
      @(negedge clk);
      tickEn = 1'b0;
      if (gap) @(negedge clk);
    end
  endtask

  initial begin
    int pc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(rdData == 8'h00, "R1 reset rdData", int'(rdData), 0);
    check(!wdogFlag && !expiredPulse, "R1 reset flag/pulse", int'({wdogFlag, expiredPulse}), 0);

    wr(8'h05, 1'b0);
    check(rdData == 8'h05, "R2 field layout", int'(rdData), 8'h05);
    wr(8'hC9, 1'b0);
    check(rdData == 8'h49, "R2 strobe reads 0", int'(rdData), 8'h49);
    wr(8'h43, 1'b0);
    check(rdData == 8'h49, "R4 locked field", int'(rdData), 8'h49);
    wr(8'h83, 1'b0);
    check(rdData == 8'h09, "R5 unlock same write", int'(rdData), 8'h09);

    // countdown of 9 with idle cycles between ticks
    ticks(8, 1'b1);
    check(!wdogFlag && !expiredPulse, "R6 before last tick", int'(wdogFlag), 0);
    ticks(1, 1'b0);
    check(expiredPulse && wdogFlag, "R6 expiry on 9th tick", int'({expiredPulse, wdogFlag}), 3);
    @(negedge clk);
    check(!expiredPulse, "R11 pulse one clock", int'(expiredPulse), 0);
    check(wdogFlag, "R9 flag sticky", int'(wdogFlag), 1);
    pc = pulseCount;
    ticks(20, 1'b0);
    check(pulseCount == pc, "R11 idle after expiry", pulseCount - pc, 0);
    flagClr = 1'b1; @(negedge clk); flagClr = 1'b0;
    check(!wdogFlag, "R9 flag clear", int'(wdogFlag), 0);

    // R5 next write accepted, then mid-run change (R8, R3 no reload)
    wr(8'h84, 1'b0);
    check(rdData == 8'h04, "R5 next write stores", int'(rdData), 8'h04);
    ticks(2, 1'b0);
    wr(8'h4A, 1'b0);
    check(rdData == 8'h4A, "R8 field changed", int'(rdData), 8'h4A);
    ticks(1, 1'b0);
    check(!expiredPulse, "R3 no reload without strobe", int'(expiredPulse), 0);
    ticks(1, 1'b0);
    check(expiredPulse, "R8 old countdown kept", int'(expiredPulse), 1);
    flagClr = 1'b1; @(negedge clk); flagClr = 1'b0;

    // R10: strobe with tick at count 1
    wr(8'hC0, 1'b0);
    check(rdData == 8'h4A, "R4 locked strobe", int'(rdData), 8'h4A);
    ticks(9, 1'b0);
    wr(8'h80, 1'b1);
    check(!expiredPulse && rdData == 8'h0A, "R10 reload wins", int'(rdData), 8'h0A);
    ticks(9, 1'b0);
    check(!expiredPulse && !wdogFlag, "R10 reload length", int'(wdogFlag), 0);
    flagClr = 1'b1;
    ticks(1, 1'b0);
    flagClr = 1'b0;
    check(expiredPulse && wdogFlag, "R9 set wins over clear", int'(wdogFlag), 1);

    // R7: timeout 0 disables
    wr(8'h80, 1'b0);
    check(rdData == 8'h00, "R7 zero stored", int'(rdData), 0);
    pc = pulseCount;
    ticks(70, 1'b0);
    check(pulseCount == pc, "R7 disabled no expiry", pulseCount - pc, 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule